// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When either of two address strobes is taken, it registers the full external address and the burst order chosen by a static order-select input. The address output then shows the registered start address. Every clock in which the active-low advance input is low moves the burst one beat forward. Only the low two address bits change during a burst. The upper bits stay at the registered value.

Two burst orders are available. The XOR order suits processor-style cache line fills: the low bits are the start bits XOR the beat number. The incrementing order adds the beat number to the start bits, modulo four. In both orders, a fifth beat brings the low bits back to the start address. A new strobe always restarts the sequence, even in a cycle in which advance is also asserted.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `addr_out` is all zeros and the order is XOR.
- R2: A clock edge with `strb_a_n` low, or `strb_b_n` low, or both, registers `addr_in`. From the next cycle on, `addr_out` equals that address exactly.
- R3: With `order_inc` = 0 at load, `addr_out[1:0]` is the loaded low bits XOR k, where k (0..3) counts the accepted advances since the load.
- R4: With `order_inc` = 1 at load, `addr_out[1:0]` is the loaded low bits plus k, modulo 4.
- R5: An edge without a strobe and with `adv_n` high leaves `addr_out` unchanged.
- R6: After four accepted advances in either order, `addr_out` is back at the loaded start address.
- R7: If a strobe and `adv_n` low arrive at the same edge, the load takes effect and the beat count restarts at zero.
- R8: Between loads, `addr_out[ADDR_W-1:2]` keeps the loaded upper bits.
- R9: `order_inc` is sampled only at a load. Changing it during a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_a_n | input | 1 | First address strobe, active low |
| strb_b_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_inc | input | 1 | Burst order: 0 = XOR, 1 = incrementing. Sampled at load |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current beat address |

## Verification
Loading and advancing can happen at the same edge. The bench causes this by asserting a strobe together with `adv_n` low partway through a burst. It expects the output in the next cycle to be the new address itself, not the address plus one beat. The sweep covers every start offset, both orders and both strobes. Within each burst it inserts a hold cycle and flips `order_inc` mid-burst, so the hold, the wrap and the ignored order change are each judged against an arithmetic model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ORD_XOR = 1'b0,
        ORD_INC = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_beat_step.sv
module burst_beat_step #(
    parameter int CNT_W = 2
) (
    input  logic             load,
    input  logic             adv,
    input  logic [CNT_W-1:0] beat_q,
    output logic [CNT_W-1:0] beat_d
);
    always_comb begin
        if (load) begin
            beat_d = '0;
        end else if (adv) begin
            beat_d = beat_q + CNT_W'(1);
        end else begin
            beat_d = beat_q;
        end
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  burst_order_e     order,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] lo
);
    logic [CNT_W-1:0] xor_lo;
    logic [CNT_W-1:0] inc_lo;

    for (genvar b = 0; b < CNT_W; b++) begin : g_xor
        assign xor_lo[b] = start[b] ^ beat[b];
    end

    assign inc_lo = start + beat;

    always_comb begin
        lo = (order == ORD_INC) ? inc_lo : xor_lo;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_a_n,
    input  logic              strb_b_n,
    input  logic              adv_n,
    input  logic              order_inc,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        burst_order_e      order;
        logic [CNT_W-1:0]  beat;
    } seq_t;

    seq_t             s_d, s_q;
    logic             load;
    logic [CNT_W-1:0] beat_d;
    logic [CNT_W-1:0] lo;

    assign load = ~strb_a_n | ~strb_b_n;

    burst_beat_step #(.CNT_W(CNT_W)) u_step (
        .load   (load),
        .adv    (~adv_n),
        .beat_q (s_q.beat),
        .beat_d (beat_d)
    );

    always_comb begin
        s_d      = s_q;
        s_d.beat = beat_d;
        if (load) begin
            s_d.base  = addr_in;
            s_d.order = order_inc ? ORD_INC : ORD_XOR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{base: '0, order: ORD_XOR, beat: '0};
        end else begin
            s_q <= s_d;
        end
    end

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .order (s_q.order),
        .start (s_q.base[CNT_W-1:0]),
        .beat  (s_q.beat),
        .lo    (lo)
    );

    assign addr_out = {s_q.base[ADDR_W-1 -: UP_W], lo};
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strb_a_n,
    input logic              strb_b_n,
    input logic              adv_n,
    input logic              order_inc,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    logic             ld;
    logic             chk_inc;
    logic [CNT_W-1:0] chk_start;
    logic [CNT_W-1:0] chk_cnt;

    assign ld = !strb_a_n || !strb_b_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_inc   <= 1'b0;
            chk_start <= '0;
            chk_cnt   <= '0;
        end else if (ld) begin
            chk_inc   <= order_inc;
            chk_start <= addr_in[CNT_W-1:0];
            chk_cnt   <= '0;
        end else if (!adv_n) begin
            chk_cnt   <= chk_cnt + CNT_W'(1);
        end
    end

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> addr_out == $past(addr_in)); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_n) |=> $stable(addr_out)); // R5

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])); // R8

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_n && chk_inc) |=>
            addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + CNT_W'(1))); // R4

    AST_XOR_BIT0_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_n && !chk_inc) |=> addr_out[0] != $past(addr_out[0])); // R3

    AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_cnt == '0) |-> addr_out[CNT_W-1:0] == chk_start); // R6
endmodule

bind burst_addr_seq burst_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb_a_n  (strb_a_n),
    .strb_b_n  (strb_b_n),
    .adv_n     (adv_n),
    .order_inc (order_inc),
    .addr_in   (addr_in),
    .addr_out  (addr_out)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strb_a_n = 1'b1;
    logic          strb_b_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_inc = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_k = '0;
    logic          m_inc = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_a_n  (strb_a_n),
        .strb_b_n  (strb_b_n),
        .adv_n     (adv_n),
        .order_inc (order_inc),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = m_inc ? 2'(m_base[1:0] + m_k) : (m_base[1:0] ^ m_k);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input string req, input logic [AW-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic cyc(input logic sa, input logic sb, input logic adv,
                       input logic ord, input logic [AW-1:0] a);
        strb_a_n  = sa;
        strb_b_n  = sb;
        adv_n     = adv;
        order_inc = ord;
        addr_in   = a;
        @(posedge clk);
        #1;
        if (!sa || !sb) begin
            m_base = a;
            m_k    = '0;
            m_inc  = ord;
        end else if (!adv) begin
            m_k = m_k + 2'd1;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] up_before;
        strb_a_n = 1'b0;
        addr_in  = 20'hABCDE;
        repeat (2) @(posedge clk);
        #1;
        check("R1 in reset", '0);
        strb_a_n = 1'b1;
        rst_n    = 1'b1;
        cyc(1, 1, 1, 0, '0);
        check("R1 after reset", '0);

        for (int mode = 0; mode < 2; mode++) begin
            for (int st = 0; st < 4; st++) begin
                for (int which = 0; which < 2; which++) begin
                    logic [AW-1:0] a;
                    a = AW'((mode * 8 + st * 2 + which) * 40503 * 4 + st);
                    cyc(which == 0 ? 1'b0 : 1'b1, which == 1 ? 1'b0 : 1'b1,
                        1'b1, mode[0], a);
                    check("R2 load", a);
                    up_before = addr_out;
                    for (int i = 0; i < 6; i++) begin
                        logic adv;
                        adv = (i == 2) ? 1'b1 : 1'b0;
                        // R9: order input driven opposite to the loaded order
                        cyc(1, 1, adv, ~mode[0], 20'h5A5A5);
                        if (adv)
                            check("R5 hold", model_addr());
                        else if (m_k == 2'd0)
                            check("R6 wrap", a);
                        else
                            check(mode == 1 ? "R4 inc order R9" : "R3 xor order R9",
                                  model_addr());
                        if (addr_out[AW-1:2] !== up_before[AW-1:2]) begin
                            checks++;
                            errors++;
                            $display("FAIL R8 upper=%h expected=%h",
                                     addr_out[AW-1:2], up_before[AW-1:2]);
                        end else begin
                            checks++;
                        end
                    end
                    // R7: strobe and advance at the same edge
                    cyc(which == 1 ? 1'b0 : 1'b1, which == 0 ? 1'b0 : 1'b1,
                        1'b0, mode[0], a ^ 20'h00F03);
                    check("R7 load beats advance", a ^ 20'h00F03);
                    cyc(1, 1, 1'b0, ~mode[0], '0);
                    check(mode == 1 ? "R4 after R7" : "R3 after R7", model_addr());
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule